// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Down-Counter

This block is the interrupt timer of a cartridge memory controller. Software sets a 16-bit cycle budget by writing it one byte at a time into two register addresses. Writing the upper byte also arms the timer. Whether that write arms it depends on an enable bit that the neighbouring register controller has already latched and presents on `arm_pend`.

While the timer is armed, each video scanline pulse takes a fixed number of CPU cycles (113 by default) from the budget. If a pulse finds that no more than one scanline's worth of cycles remains, the timer raises its interrupt line and disarms itself. The interrupt line stays high until the acknowledge input or reset clears it. A register write in the same cycle as a scanline pulse wins, and that pulse is dropped.

Top module: `scan_irq_timer`

## Requirements
- R1: A write with `wr_en`=1 to address 0x8200 loads `wr_data` into bits 7:0 of the count and leaves bits 15:8 as they were.
- R2: A write with `wr_en`=1 to address 0x8201 loads `wr_data` into bits 15:8 of the count, leaves bits 7:0 as they were, and sets the armed state to the value of `arm_pend` in that cycle (1 arms, 0 disarms).
- R3: A `line_tick` while armed, with the count at 113 or less, sets `irq` at the next clock edge and disarms the timer; the count is left unchanged.
- R4: A `line_tick` while armed, with the count above 113, subtracts 113 from the count and raises no interrupt. A count N loaded while armed therefore fires on tick max(1, ceil(N/113)).
- R5: While disarmed, `line_tick` changes neither the count nor `irq`.
- R6: When a count write and a `line_tick` fall in the same cycle, the write is applied and the tick is ignored.
- R7: Once set, `irq` stays at 1 until `irq_ack` is 1 at a clock edge. Count writes do not clear it.
- R8: If a firing tick and `irq_ack` fall in the same cycle, `irq` is 1 after that edge.
- R9: While `rst_n` is 0, the count is 0, the timer is disarmed and `irq` is 0.
- R10: A write to any address other than 0x8200 or 0x8201, or any cycle with `wr_en`=0, leaves the count and the armed state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| arm_pend | input | 1 | Latched enable bit, copied into the armed state when the upper byte is written |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq_ack | input | 1 | Clears the interrupt line |
| irq | output | 1 | Interrupt request, held high until acknowledged |

## Verification
The assertions assume that `line_tick`, `wr_en` and `irq_ack` are synchronous to `clk` and settled at each rising edge. They also assume that a write strobe lasts one cycle per intended write. None of them needs ticks or writes to be spaced apart, because write priority is built into the properties themselves. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge, so these conditions always hold. It reads the count only through the tick on which the interrupt fires, counted from a known load.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    // Kind of register access decoded from one CPU bus cycle
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_LO   = 2'd1,
        WK_HI   = 2'd2
    } wr_kind_e;

    // Default geometry of the timer
    localparam int unsigned SIRQ_ADDR_W = 16;
    localparam int unsigned SIRQ_DATA_W = 8;
    localparam int unsigned SIRQ_STEP   = 113;

endpackage

// File: rtl/scan_irq_decode.sv
module scan_irq_decode
    import scan_irq_pkg::*;
#(
    parameter int unsigned     ADDR_W  = SIRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'h8200,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'h8201
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_kind_e          kind
);

    logic hit_lo;
    logic hit_hi;

    always_comb begin
        hit_lo = wr_en && (wr_addr == LO_ADDR);
        hit_hi = wr_en && (wr_addr == HI_ADDR);
        if (hit_lo) begin
            kind = WK_LO;
        end else if (hit_hi) begin
            kind = WK_HI;
        end else begin
            kind = WK_NONE;
        end
    end

endmodule

// File: rtl/scan_irq_count.sv
module scan_irq_count
    import scan_irq_pkg::*;
#(
    parameter int unsigned DATA_W = SIRQ_DATA_W,
    parameter int unsigned STEP   = SIRQ_STEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_pend,
    input  logic              line_tick,
    output logic              fire
);

    localparam int unsigned     CNT_W  = 2 * DATA_W;
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
    } cnt_st_t;

    cnt_st_t st_d;
    cnt_st_t st_q;
    logic    tick_live;
    logic    in_reach;

    always_comb begin
        st_d      = st_q;
        tick_live = line_tick && st_q.en && (kind == WK_NONE);
        in_reach  = (st_q.cnt <= STEP_V);
        fire      = tick_live && in_reach;
        unique case (kind)
            WK_LO: st_d.cnt[DATA_W-1:0] = wr_data;
            WK_HI: begin
                st_d.cnt[CNT_W-1:DATA_W] = wr_data;
                st_d.en                  = arm_pend;
            end
            default: begin
                if (tick_live) begin
                    if (in_reach) begin
                        st_d.en = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - STEP_V;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_LO |=> st_q.cnt == {$past(st_q.cnt[CNT_W-1:DATA_W]), $past(wr_data)}); // R1
    AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_HI |=> st_q.cnt == {$past(wr_data), $past(st_q.cnt[DATA_W-1:0])} && st_q.en == $past(arm_pend)); // R2
    AST_FIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !st_q.en && $stable(st_q.cnt)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick && st_q.en && kind == WK_NONE && st_q.cnt > STEP_V |=> st_q.cnt == $past(st_q.cnt) - STEP_V && st_q.en); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en && kind == WK_NONE |=> $stable(st_q.cnt) && !st_q.en); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        kind != WK_NONE |-> !fire); // R6
    AST_NO_DECODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_NONE && !line_tick |=> $stable(st_q.cnt) && $stable(st_q.en)); // R10

endmodule

// File: rtl/scan_irq_flag.sv
module scan_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic irq_ack,
    output logic irq
);

    typedef struct packed {
        logic irq;
    } flag_st_t;

    flag_st_t st_d;
    flag_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.irq = 1'b1;
        end else if (irq_ack) begin
            st_d.irq = 1'b0;
        end
        irq = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq); // R7
    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        fire && irq_ack |=> irq); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !fire |=> !irq); // R7

endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer
    import scan_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W  = SIRQ_ADDR_W,
    parameter int unsigned       DATA_W  = SIRQ_DATA_W,
    parameter int unsigned       STEP    = SIRQ_STEP,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'h8200,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'h8201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_pend,
    input  logic              line_tick,
    input  logic              irq_ack,
    output logic              irq
);

    wr_kind_e kind;
    logic     fire;

    scan_irq_decode #(
        .ADDR_W (ADDR_W),
        .LO_ADDR(LO_ADDR),
        .HI_ADDR(HI_ADDR)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .kind   (kind)
    );

    scan_irq_count #(
        .DATA_W(DATA_W),
        .STEP  (STEP)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wr_data  (wr_data),
        .arm_pend (arm_pend),
        .line_tick(line_tick),
        .fire     (fire)
    );

    scan_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .irq_ack(irq_ack),
        .irq    (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R9
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !line_tick |=> !irq); // R5

endmodule

// File: tb/sim_scan_irq_timer.sv
module sim_scan_irq_timer;

    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 113;
    localparam logic [15:0] A_LO = 16'h8200;
    localparam logic [15:0] A_HI = 16'h8201;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        arm_pend = 1'b0;
    logic        line_tick = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_irq_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .arm_pend (arm_pend),
        .line_tick(line_tick),
        .irq_ack  (irq_ack),
        .irq      (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ticks_to_fire(input int n);
        return (n <= STEP) ? 1 : (n + STEP - 1) / STEP;
    endfunction

    // One bus write, captured by exactly one rising edge
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic pend);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; arm_pend = pend;
        @(negedge clk);
        wr_en = 1'b0; arm_pend = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Ticks k-1 times expecting silence, then once more expecting irq
    task automatic expect_fire_on(input int k, input string tag);
        for (int i = 1; i < k; i++) begin
            tick();
            if (irq) begin
                check(1'b0, tag, i, k);
                return;
            end
        end
        check(irq == 1'b0, {tag, " quiet before last tick"}, irq, 0);
        tick();
        check(irq == 1'b1, {tag, " fires on computed tick"}, irq, 1);
    endtask

    task automatic load(input int n, input logic pend);
        bus_wr(A_LO, n[7:0], 1'b0);
        bus_wr(A_HI, n[15:8], pend);
    endtask

    task automatic t_reset();
        do_reset();
        check(irq == 1'b0, "R9 irq low after reset", irq, 0);
        for (int i = 0; i < 3; i++) tick();
        check(irq == 1'b0, "R9 disarmed after reset", irq, 0);
        // count zero from reset: arm by upper byte 0 keeps lower byte 0 -> fires on first tick
        bus_wr(A_HI, 8'h00, 1'b1);
        tick();
        check(irq == 1'b1, "R9 count zero after reset", irq, 1);
        ack();
        check(irq == 1'b0, "R7 ack clears irq", irq, 0);
    endtask

    task automatic t_boundaries();
        load(113, 1'b1);
        expect_fire_on(1, "R3 count 113");
        ack();
        load(114, 1'b1);
        expect_fire_on(2, "R4 count 114");
        ack();
        load(1000, 1'b1);
        expect_fire_on(ticks_to_fire(1000), "R4 count 1000");
        ack();
        load(16'hFFFF, 1'b1);
        expect_fire_on(ticks_to_fire(65535), "R4 count 65535");
        ack();
    endtask

    task automatic t_disarm_after_fire();
        load(50, 1'b1);
        tick();
        check(irq == 1'b1, "R3 fire at 50", irq, 1);
        ack();
        for (int i = 0; i < 4; i++) tick();
        check(irq == 1'b0, "R3 self-disarmed after fire", irq, 0);
    endtask

    task automatic t_lo_keeps_hi();
        bus_wr(A_LO, 8'h00, 1'b0);
        bus_wr(A_HI, 8'h02, 1'b1);   // armed, count 0x0200
        bus_wr(A_LO, 8'h58, 1'b0);   // count 0x0258 = 600 if upper kept
        expect_fire_on(ticks_to_fire(600), "R1 low write keeps upper byte");
        ack();
    endtask

    task automatic t_pend_zero();
        load(300, 1'b0);
        for (int i = 0; i < 6; i++) tick();
        check(irq == 1'b0, "R2 pend=0 leaves timer disarmed", irq, 0);
        // rearm then disarm via upper write with pend=0
        bus_wr(A_HI, 8'h01, 1'b1);
        bus_wr(A_HI, 8'h01, 1'b0);
        for (int i = 0; i < 6; i++) tick();
        check(irq == 1'b0, "R2 upper write with pend=0 disarms", irq, 0);
    endtask

    task automatic t_idle_hold();
        load(16'h0110, 1'b0);        // 272, disarmed
        for (int i = 0; i < 20; i++) tick();
        check(irq == 1'b0, "R5 no irq while disarmed", irq, 0);
        bus_wr(A_HI, 8'h01, 1'b1);   // arm, count still 272 if held
        expect_fire_on(ticks_to_fire(272), "R5 count held while disarmed");
        ack();
    endtask

    task automatic t_collision();
        load(200, 1'b1);             // needs 2 ticks
        @(negedge clk);
        line_tick = 1'b1; wr_en = 1'b1; wr_addr = A_LO; wr_data = 8'd200;
        @(negedge clk);
        line_tick = 1'b0; wr_en = 1'b0;
        check(irq == 1'b0, "R6 tick dropped on write cycle", irq, 0);
        expect_fire_on(2, "R6 count untouched by colliding tick");
        ack();
    endtask

    task automatic t_sticky();
        load(10, 1'b1);
        tick();
        check(irq == 1'b1, "R7 irq set", irq, 1);
        bus_wr(A_LO, 8'h40, 1'b0);
        bus_wr(A_HI, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R7 writes do not clear irq", irq, 1);
        ack();
        check(irq == 1'b0, "R7 ack clears", irq, 0);
    endtask

    task automatic t_set_vs_ack();
        load(20, 1'b1);
        @(negedge clk);
        line_tick = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        line_tick = 1'b0; irq_ack = 1'b0;
        check(irq == 1'b1, "R8 set beats ack", irq, 1);
        ack();
    endtask

    task automatic t_other_addr();
        load(200, 1'b1);             // expect 2 ticks
        bus_wr(16'h8202, 8'hFF, 1'b1);
        bus_wr(16'h8300, 8'hFF, 1'b1);
        bus_wr(16'h0200, 8'hFF, 1'b1);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = A_HI; wr_data = 8'hFF; arm_pend = 1'b1;
        @(negedge clk);
        arm_pend = 1'b0;
        expect_fire_on(2, "R10 foreign writes ignored");
        ack();
        load(5, 1'b0);               // disarmed
        @(negedge clk);
        wr_en = 1'b0; wr_addr = A_HI; wr_data = 8'h00; arm_pend = 1'b1;
        @(negedge clk);
        arm_pend = 1'b0;
        tick();
        check(irq == 1'b0, "R10 no arm without wr_en", irq, 0);
    endtask

    task automatic t_reset_midway();
        load(500, 1'b1);
        tick();
        do_reset();
        check(irq == 1'b0, "R9 reset mid-count", irq, 0);
        for (int i = 0; i < 6; i++) tick();
        check(irq == 1'b0, "R9 reset disarms", irq, 0);
    endtask

    initial begin
        t_reset();
        t_boundaries();
        t_disarm_after_fire();
        t_lo_keeps_hi();
        t_pend_zero();
        t_idle_hold();
        t_collision();
        t_sticky();
        t_set_vs_ack();
        t_other_addr();
        t_reset_midway();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule